// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback and Reference Divider

This block holds the programmable counters of a frequency synthesizer. On the feedback side, a digital model of a dual-modulus prescaler divides the VCO clock by P+1 or P. A program counter counts whole prescaler cycles. A swallow comparison keeps the prescaler at P+1 for the first A of those cycles and at P for the rest. Each feedback period is therefore N = P*B + A VCO cycles. A select bit picks P = 16 or P = 32. On the reference side, a separate counter divides the reference clock by R. The two divided pulses go to a phase detector, which lives outside this block.

New A, B, R and select values are sampled only at the terminal count of their own counter, so a period never comes out short or long. B or R below 3 is raised to 3, and A is limited to the effective B. Either correction raises an error flag for the period that uses the corrected value. Reset marks both sides as fresh. The first clock edge after reset loads the words, and counting starts on the next edge.

Top module: `pulse_swallow_divider`

## Requirements
- R1: Once a word set is in effect, fb_pulse rises every N = P*B + A cycles of clk_vco, with P = 16 when sel_32 = 0 and P = 32 when sel_32 = 1.
- R2: Within each feedback period, mod_ctl (1 = divide by P+1) is high for exactly A*(P+1) clk_vco cycles, all at the start of the period. It rises only on the cycle that follows a reload.
- R3: A b_word below 3 is used as 3, and fb_err is 1 from the reload that sampled it until the next reload.
- R4: An a_word greater than the effective B is used as that B, and fb_err is 1 for that period. A legal word set gives fb_err = 0.
- R5: ref_pulse rises every R cycles of clk_ref. An r_word below 3 is used as 3 and sets ref_err for that period; a legal r_word clears ref_err.
- R6: fb_pulse and ref_pulse are high for one cycle of their own clock, in the cycle that follows the terminal edge.
- R7: A change of the input words in the middle of a period leaves that period's length unchanged. A change presented in the cycle just before the terminal edge is used for the following period.
- R8: While rst_n is low, fb_pulse, ref_pulse, mod_ctl, fb_err and ref_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | VCO clock that drives the prescaler |
| clk_ref | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| sel_32 | input | 1 | Prescaler select: 0 = 16/17, 1 = 32/33 |
| a_word | input | 7 | Swallow count A |
| b_word | input | 11 | Program count B |
| r_word | input | 15 | Reference count R |
| mod_ctl | output | 1 | Modulus control, 1 = divide by P+1 |
| fb_pulse | output | 1 | One-cycle pulse at the feedback terminal count |
| ref_pulse | output | 1 | One-cycle pulse at the reference terminal count |
| fb_err | output | 1 | A or B word was corrected for the current period |
| ref_err | output | 1 | R word was corrected for the current period |

## Verification
A reload at the terminal count and a change of the input words can land on the same clk_vco edge. The bench provokes this by counting clk_vco cycles from a known pulse. It changes A and B at the falling edge just before the terminal edge, so the new words are the ones sampled there. It judges the result by the lengths of two periods: the period that is ending must keep the old length, and the next one must have the new N and the new count of P+1 cycles. A separate case changes the words in mid-period and checks that the period in progress keeps its length.

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider #(
  parameter int AW    = 7,
  parameter int BW    = 11,
  parameter int RW    = 15,
  parameter int P_LO  = 16,
  parameter int P_HI  = 32,
  parameter int B_MIN = 3,
  parameter int R_MIN = 3
) (
  input  logic          clk_vco,
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic          sel_32,
  input  logic [AW-1:0] a_word,
  input  logic [BW-1:0] b_word,
  input  logic [RW-1:0] r_word,
  output logic          mod_ctl,
  output logic          fb_pulse,
  output logic          ref_pulse,
  output logic          fb_err,
  output logic          ref_err
);
  localparam int PW = $clog2(P_HI + 2);

  logic          fb_fresh, p_sel;
  logic [PW-1:0] pre_cnt, pre_top;
  logic [BW-1:0] cyc_cnt, b_lat, b_eff;
  logic [AW-1:0] a_lat, a_eff;
  logic          b_low, a_high, pre_tc, fb_tc;

  assign b_low   = b_word < BW'(B_MIN);
  assign b_eff   = b_low ? BW'(B_MIN) : b_word;
  assign a_high  = {{(BW-AW){1'b0}}, a_word} > b_eff;
  assign a_eff   = a_high ? b_eff[AW-1:0] : a_word;

  assign mod_ctl = cyc_cnt < {{(BW-AW){1'b0}}, a_lat};
  assign pre_top = (p_sel ? PW'(P_HI) : PW'(P_LO)) - PW'(1) + PW'(mod_ctl);
  assign pre_tc  = pre_cnt == pre_top;
  assign fb_tc   = pre_tc && (cyc_cnt == b_lat - BW'(1));

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) begin
      fb_fresh <= 1'b1;
      pre_cnt  <= '0;
      cyc_cnt  <= '0;
      a_lat    <= '0;
      b_lat    <= '0;
      p_sel    <= 1'b0;
      fb_pulse <= 1'b0;
      fb_err   <= 1'b0;
    end else begin
      fb_pulse <= 1'b0;
      if (fb_fresh || fb_tc) begin
        a_lat    <= a_eff;
        b_lat    <= b_eff;
        p_sel    <= sel_32;
        fb_err   <= b_low || a_high;
        pre_cnt  <= '0;
        cyc_cnt  <= '0;
        fb_pulse <= !fb_fresh;
        fb_fresh <= 1'b0;
      end else if (pre_tc) begin
        pre_cnt <= '0;
        cyc_cnt <= cyc_cnt + BW'(1);
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end
  end

  logic          ref_fresh, r_low;
  logic [RW-1:0] r_cnt, r_lat;

  assign r_low = r_word < RW'(R_MIN);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ref_fresh <= 1'b1;
      r_cnt     <= '0;
      r_lat     <= '0;
      ref_pulse <= 1'b0;
      ref_err   <= 1'b0;
    end else begin
      ref_pulse <= 1'b0;
      if (ref_fresh || (r_cnt == r_lat - RW'(1))) begin
        r_lat     <= r_low ? RW'(R_MIN) : r_word;
        ref_err   <= r_low;
        r_cnt     <= '0;
        ref_pulse <= !ref_fresh;
        ref_fresh <= 1'b0;
      end else begin
        r_cnt <= r_cnt + RW'(1);
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_divider_chk.sv
module pulse_swallow_divider_chk #(
  parameter int AW = 7,
  parameter int BW = 11
) (
  input logic          clk_vco,
  input logic          clk_ref,
  input logic          rst_n,
  input logic          mod_ctl,
  input logic          fb_pulse,
  input logic          ref_pulse,
  input logic          fb_err,
  input logic          ref_err,
  input logic          fb_fresh,
  input logic          ref_fresh,
  input logic [AW-1:0] a_lat,
  input logic [BW-1:0] b_lat
);
  AST_FB_ONE_CYCLE: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R6
  AST_REF_ONE_CYCLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse); // R6
  AST_MOD_RISE_AT_RELOAD: assert property (@(posedge clk_vco) disable iff (!rst_n)
    $rose(mod_ctl) |-> (fb_pulse || $past(fb_fresh))); // R2
  AST_FB_ERR_HELD: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (!fb_pulse && !$past(fb_fresh)) |-> $stable(fb_err)); // R7
  AST_REF_ERR_HELD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!ref_pulse && !$past(ref_fresh)) |-> $stable(ref_err)); // R5
  AST_B_FLOOR: assert property (@(posedge clk_vco) disable iff (!rst_n)
    !fb_fresh |-> (b_lat >= BW'(3))); // R3
  AST_A_NOT_ABOVE_B: assert property (@(posedge clk_vco) disable iff (!rst_n)
    {{(BW-AW){1'b0}}, a_lat} <= b_lat); // R4
endmodule

bind pulse_swallow_divider pulse_swallow_divider_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk_vco(clk_vco), .clk_ref(clk_ref), .rst_n(rst_n),
  .mod_ctl(mod_ctl), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
  .fb_err(fb_err), .ref_err(ref_err),
  .fb_fresh(fb_fresh), .ref_fresh(ref_fresh),
  .a_lat(a_lat), .b_lat(b_lat)
);

// File: tb/pulse_swallow_divider_test.sv
module pulse_swallow_divider_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_32 = 1'b0;
  logic [6:0] a_word = '0;
  logic [10:0] b_word = 11'd3;
  logic [14:0] r_word = 15'd3;
  logic mod_ctl, fb_pulse, ref_pulse, fb_err, ref_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_swallow_divider uut (
    .clk_vco(clk), .clk_ref(clk), .rst_n(rst_n), .sel_32(sel_32),
    .a_word(a_word), .b_word(b_word), .r_word(r_word),
    .mod_ctl(mod_ctl), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
    .fb_err(fb_err), .ref_err(ref_err)
  );

  typedef struct packed {
    logic        ps;
    logic [6:0]  a;
    logic [10:0] b;
    logic [14:0] r;
    logic        fe;
    logic        re;
  } vec_t;

  localparam vec_t VEC [0:6] = '{
    '{1'b0, 7'd0,   11'd3,   15'd3,   1'b0, 1'b0},
    '{1'b0, 7'd5,   11'd10,  15'd7,   1'b0, 1'b0},
    '{1'b1, 7'd3,   11'd4,   15'd100, 1'b0, 1'b0},
    '{1'b1, 7'd127, 11'd200, 15'd5,   1'b0, 1'b0},
    '{1'b0, 7'd2,   11'd1,   15'd1,   1'b1, 1'b1},
    '{1'b0, 7'd9,   11'd4,   15'd0,   1'b1, 1'b1},
    '{1'b0, 7'd4,   11'd4,   15'd3,   1'b0, 1'b0}
  };

  function automatic int eff_b(int b);
    return (b < 3) ? 3 : b;
  endfunction
  function automatic int eff_a(int a, int b);
    return (a > eff_b(b)) ? eff_b(b) : a;
  endfunction
  function automatic int p_of(logic ps);
    return ps ? 32 : 16;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sync_fb();
    @(negedge clk);
    while (!fb_pulse) @(negedge clk);
  endtask

  task automatic sync_ref();
    @(negedge clk);
    while (!ref_pulse) @(negedge clk);
  endtask

  task automatic meas_fb(output int per, output int mh);
    per = 0;
    mh = 0;
    do begin
      if (mod_ctl) mh++;
      @(negedge clk);
      per++;
    end while (!fb_pulse);
  endtask

  task automatic meas_ref(output int per);
    per = 0;
    do begin
      @(negedge clk);
      per++;
    end while (!ref_pulse);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int per, mh, cnt, n_exp, errv;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 fb_pulse", fb_pulse, 0);
    chk("R8 ref_pulse", ref_pulse, 0);
    chk("R8 mod_ctl", mod_ctl, 0);
    chk("R8 fb_err", fb_err, 0);
    chk("R8 ref_err", ref_err, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 7; i++) begin
      sel_32 = VEC[i].ps;
      a_word = VEC[i].a;
      b_word = VEC[i].b;
      r_word = VEC[i].r;
      sync_fb();
      errv = fb_err;
      meas_fb(per, mh);
      n_exp = p_of(VEC[i].ps) * eff_b(int'(VEC[i].b)) + eff_a(int'(VEC[i].a), int'(VEC[i].b));
      chk($sformatf("R1 period vec%0d", i), per, n_exp);
      chk($sformatf("R2 mod cycles vec%0d", i), mh,
          eff_a(int'(VEC[i].a), int'(VEC[i].b)) * (p_of(VEC[i].ps) + 1));
      if (int'(VEC[i].b) < 3)
        chk($sformatf("R3 fb_err vec%0d", i), errv, int'(VEC[i].fe));
      else
        chk($sformatf("R4 fb_err vec%0d", i), errv, int'(VEC[i].fe));
      @(negedge clk);
      chk($sformatf("R6 fb width vec%0d", i), fb_pulse, 0);
      sync_ref();
      sync_ref();
      errv = ref_err;
      meas_ref(per);
      chk($sformatf("R5 ref period vec%0d", i), per, (int'(VEC[i].r) < 3) ? 3 : int'(VEC[i].r));
      chk($sformatf("R5 ref_err vec%0d", i), errv, int'(VEC[i].re));
      @(negedge clk);
      chk($sformatf("R6 ref width vec%0d", i), ref_pulse, 0);
    end

    // R7 mid-period change: running N=165, switch to N=48 after 20 cycles
    sel_32 = 1'b0; a_word = 7'd5; b_word = 11'd10;
    sync_fb();
    meas_fb(per, mh);
    cnt = 0;
    repeat (20) begin @(negedge clk); cnt++; end
    a_word = 7'd0; b_word = 11'd3;
    while (!fb_pulse) begin @(negedge clk); cnt++; end
    chk("R7 period kept after mid change", cnt, 165);
    meas_fb(per, mh);
    chk("R7 new period after reload", per, 48);

    // R7 change presented just before the terminal edge
    cnt = 0;
    repeat (47) begin @(negedge clk); cnt++; end
    a_word = 7'd5; b_word = 11'd10;
    while (!fb_pulse) begin @(negedge clk); cnt++; end
    chk("R7 ending period at coincident change", cnt, 48);
    meas_fb(per, mh);
    chk("R7 period after coincident change", per, 165);
    chk("R2 mod cycles after coincident change", mh, 85);

    finish_run();
  end
endmodule